// File: doc/BRIEF.md
# Breakpoint Trigger Configuration Bank

This block holds the configuration of a small set of hardware breakpoint triggers. Software reaches it through a narrow register port with four addresses. A select register picks one trigger. A control register and a compare-value register act on the trigger that is selected. A fourth address is reserved and always reads zero. Each trigger keeps its match-control fields and an XLEN-wide compare value.

The bank does not compare addresses and does not carry out trigger actions. It stores and masks configuration. It reports three summary flags that tell the memory pipeline whether any trigger watches instruction fetches, loads or stores. Triggers owned by the debugger can only be changed while the hart is in debug mode. Every accepted change to a trigger produces a one-cycle notice, so that downstream translation caches can flush.

Top module: `brk_trig_bank`

## Requirements
- R1: After reset the select register reads 0. Every trigger's control register reads type value 2 in bits [XLEN-1:XLEN-4], with all other bits 0. Every compare register reads 0, and all three watch flags are 0.
- R2: A write to address 0 (select) takes effect only when the written value is below NTRIG. Otherwise the previous selection is kept.
- R3: A write to address 1 (control) or address 2 (compare) is ignored when the selected trigger's dmode bit is 1 and dbg_mode is 0.
- R4: The control register layout is as follows. dmode is at bit XLEN-5. Bits [XLEN-6:20] read 0. select is at bit 19 and timing at bit 18. action is at [17:12] and chain at bit 11. match is at [10:7]. The privilege enables m, h, s and u are at bits 6, 5, 4 and 3. execute is at bit 2, store at bit 1 and load at bit 0. A write stores all of these fields.
- R5: When a control write has execute (bit 2) set, the stored timing bit becomes 0, whatever value was written to it.
- R6: Address 3 always reads 0. A control or compare read whose selected index is not below NTRIG returns 0.
- R7: watch_fetch is the OR of all execute bits. watch_load is the OR of all load bits. watch_store is the OR of all store bits. Each flag follows a stored change in the cycle after the write edge.
- R8: cfg_changed is high for exactly the one cycle that follows each accepted control or compare write. It stays low after select writes and after locked writes.
- R9: A compare write stores the full XLEN value in the selected trigger only. The other triggers keep their contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_we | input | 1 | Write strobe for the register port |
| csr_addr | input | 2 | 0 select, 1 control, 2 compare, 3 reserved |
| csr_wdata | input | XLEN | Write data |
| csr_rdata | output | XLEN | Combinational read data for csr_addr |
| dbg_mode | input | 1 | Hart is currently in debug mode |
| watch_fetch | output | 1 | Some trigger has execute set |
| watch_load | output | 1 | Some trigger has load set |
| watch_store | output | 1 | Some trigger has store set |
| cfg_changed | output | 1 | One-cycle pulse after an accepted trigger write |

## Verification
The hardest state to reach is a trigger that debug mode owns, being written from outside debug mode. To build it, the stimulus raises dbg_mode and writes a control value with dmode set. It then drops dbg_mode and tries both a control write and a compare write. Read-back and a silent cfg_changed show that nothing moved. The timing override is reached by writing all-ones, and also by writing timing without execute, so that the forced value can be told apart from the stored one.

// File: rtl/brk_trig_pkg.sv
package brk_trig_pkg;

  typedef enum logic [1:0] {
    ADDR_SEL  = 2'd0,
    ADDR_CTRL = 2'd1,
    ADDR_CMP  = 2'd2,
    ADDR_AUX  = 2'd3
  } trig_addr_e;

  // Low 20 bits match the control word layout [19:0]; dmode sits above them.
  typedef struct packed {
    logic       dmode;
    logic       sel;
    logic       timing;
    logic [5:0] action;
    logic       chain;
    logic [3:0] match;
    logic       m;
    logic       h;
    logic       s;
    logic       u;
    logic       exec;
    logic       store;
    logic       load;
  } trig_ctrl_t;

  localparam logic [3:0] TRIG_TYPE = 4'd2;

endpackage

// File: rtl/brk_trig_slot.sv
module brk_trig_slot
  import brk_trig_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_ctrl,
  input  logic            wr_cmp,
  input  logic [XLEN-1:0] wdata,
  input  logic            dbg_mode,
  output trig_ctrl_t      ctrl_q,
  output logic [XLEN-1:0] cmp_q,
  output logic            locked
);

  localparam int DMODE_BIT = XLEN - 5;

  trig_ctrl_t      ctrl_d;
  logic [XLEN-1:0] cmp_d;
  logic            ctrl_en;
  logic            cmp_en;

  assign locked  = ctrl_q.dmode & ~dbg_mode;
  assign ctrl_en = wr_ctrl & ~locked;
  assign cmp_en  = wr_cmp & ~locked;

  always_comb begin
    ctrl_d = {wdata[DMODE_BIT], wdata[19:0]};
    if (ctrl_d.exec) ctrl_d.timing = 1'b0;
    cmp_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (ctrl_en) begin
      ctrl_q <= ctrl_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q <= '0;
    end else if (cmp_en) begin
      cmp_q <= cmp_d;
    end
  end

  // R3: a locked trigger keeps its state across an attempted write
  a_r3_locked_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ((wr_ctrl || wr_cmp) && ctrl_q.dmode && !dbg_mode) |=> ($stable(ctrl_q) && $stable(cmp_q)));

  // R5: an accepted write with execute set leaves timing cleared
  a_r5_exec_timing: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && !locked && wdata[2]) |=> (ctrl_q.exec && !ctrl_q.timing));

endmodule

// File: rtl/brk_trig_rdmux.sv
module brk_trig_rdmux
  import brk_trig_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int NTRIG = 4,
  parameter int SEL_W = 2
) (
  input  logic [1:0]       addr,
  input  logic [SEL_W-1:0] sel,
  input  trig_ctrl_t       ctrl [NTRIG],
  input  logic [XLEN-1:0]  cmp  [NTRIG],
  output logic [XLEN-1:0]  rdata
);

  localparam int DMODE_BIT = XLEN - 5;

  logic            sel_ok;
  trig_ctrl_t      cur;
  logic [XLEN-1:0] ctrl_word;

  assign sel_ok = (int'(sel) < NTRIG);

  always_comb begin
    cur = '0;
    for (int i = 0; i < NTRIG; i++) begin
      if (int'(sel) == i) cur = ctrl[i];
    end
    ctrl_word                   = '0;
    ctrl_word[XLEN-1:XLEN-4]    = TRIG_TYPE;
    ctrl_word[DMODE_BIT]        = cur.dmode;
    ctrl_word[19:0]             = cur[19:0];
  end

  always_comb begin
    rdata = '0;
    unique case (trig_addr_e'(addr))
      ADDR_SEL:  rdata = XLEN'(sel);
      ADDR_CTRL: rdata = sel_ok ? ctrl_word : '0;
      ADDR_CMP: begin
        for (int i = 0; i < NTRIG; i++) begin
          if (int'(sel) == i) rdata = cmp[i];
        end
      end
      ADDR_AUX:  rdata = '0;
      default:   rdata = '0;
    endcase
  end

endmodule

// File: rtl/brk_trig_summary.sv
module brk_trig_summary
  import brk_trig_pkg::*;
#(
  parameter int NTRIG = 4
) (
  input  trig_ctrl_t ctrl [NTRIG],
  output logic       any_exec,
  output logic       any_load,
  output logic       any_store
);

  logic [NTRIG-1:0] exec_v;
  logic [NTRIG-1:0] load_v;
  logic [NTRIG-1:0] store_v;

  for (genvar g = 0; g < NTRIG; g++) begin : g_collect
    assign exec_v[g]  = ctrl[g].exec;
    assign load_v[g]  = ctrl[g].load;
    assign store_v[g] = ctrl[g].store;
  end

  assign any_exec  = |exec_v;
  assign any_load  = |load_v;
  assign any_store = |store_v;

endmodule

// File: rtl/brk_trig_bank.sv
module brk_trig_bank
  import brk_trig_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int NTRIG = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            csr_we,
  input  logic [1:0]      csr_addr,
  input  logic [XLEN-1:0] csr_wdata,
  output logic [XLEN-1:0] csr_rdata,
  input  logic            dbg_mode,
  output logic            watch_fetch,
  output logic            watch_load,
  output logic            watch_store,
  output logic            cfg_changed
);

  localparam int SEL_W = (NTRIG > 1) ? $clog2(NTRIG) : 1;

  logic [SEL_W-1:0] sel_q, sel_d;
  logic             sel_en;
  logic             chg_d;
  logic             wr_ctrl_any, wr_cmp_any;
  logic [NTRIG-1:0] lock_v;
  logic             sel_locked;

  trig_ctrl_t      ctrl_a [NTRIG];
  logic [XLEN-1:0] cmp_a  [NTRIG];

  assign wr_ctrl_any = csr_we && (trig_addr_e'(csr_addr) == ADDR_CTRL);
  assign wr_cmp_any  = csr_we && (trig_addr_e'(csr_addr) == ADDR_CMP);

  always_comb begin
    sel_locked = 1'b0;
    for (int i = 0; i < NTRIG; i++) begin
      if (int'(sel_q) == i) sel_locked = lock_v[i];
    end
  end

  // Select register next state
  always_comb begin
    sel_en = csr_we && (trig_addr_e'(csr_addr) == ADDR_SEL) && (csr_wdata < XLEN'(NTRIG));
    sel_d  = csr_wdata[SEL_W-1:0];
    chg_d  = (wr_ctrl_any || wr_cmp_any) && !sel_locked;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
    end else if (sel_en) begin
      sel_q <= sel_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_changed <= 1'b0;
    end else begin
      cfg_changed <= chg_d;
    end
  end

  for (genvar g = 0; g < NTRIG; g++) begin : g_slot
    logic hit;
    assign hit = (int'(sel_q) == g);
    brk_trig_slot #(.XLEN(XLEN)) u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_ctrl  (wr_ctrl_any && hit),
      .wr_cmp   (wr_cmp_any && hit),
      .wdata    (csr_wdata),
      .dbg_mode (dbg_mode),
      .ctrl_q   (ctrl_a[g]),
      .cmp_q    (cmp_a[g]),
      .locked   (lock_v[g])
    );
  end

  brk_trig_rdmux #(.XLEN(XLEN), .NTRIG(NTRIG), .SEL_W(SEL_W)) u_rdmux (
    .addr  (csr_addr),
    .sel   (sel_q),
    .ctrl  (ctrl_a),
    .cmp   (cmp_a),
    .rdata (csr_rdata)
  );

  brk_trig_summary #(.NTRIG(NTRIG)) u_summary (
    .ctrl      (ctrl_a),
    .any_exec  (watch_fetch),
    .any_load  (watch_load),
    .any_store (watch_store)
  );

  // R2: selection never leaves the implemented range
  a_r2_sel_range: assert property (@(posedge clk) disable iff (!rst_n)
    int'(sel_q) < NTRIG);

  // R2: an out-of-range select write leaves the selection unchanged
  a_r2_sel_reject: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_we && csr_addr == 2'd0 && csr_wdata >= XLEN'(NTRIG)) |=> $stable(sel_q));

  // R8: a change notice always follows a write strobe on the port
  a_r8_pulse_cause: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_changed |-> $past(csr_we));

  // R6: the reserved address reads zero
  a_r6_aux_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_addr == 2'd3) |-> (csr_rdata == '0));

endmodule

// File: tb/test_brk_trig_bank.sv
module test_brk_trig_bank;

  localparam int XLEN  = 32;
  localparam int NTRIG = 4;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            csr_we;
  logic [1:0]      csr_addr;
  logic [XLEN-1:0] csr_wdata;
  logic [XLEN-1:0] csr_rdata;
  logic            dbg_mode;
  logic            watch_fetch, watch_load, watch_store, cfg_changed;

  int n_run  = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  brk_trig_bank #(.XLEN(XLEN), .NTRIG(NTRIG)) i_brk_trig_bank (
    .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_addr(csr_addr),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .dbg_mode(dbg_mode),
    .watch_fetch(watch_fetch), .watch_load(watch_load),
    .watch_store(watch_store), .cfg_changed(cfg_changed)
  );

  // {write addr, write data, dbg_mode, read addr, expected read}
  localparam int NV = 11;
  localparam logic [68:0] VEC [NV] = '{
    {2'd0, 32'h0000_0001, 1'b0, 2'd0, 32'h0000_0001}, // R2 valid select
    {2'd1, 32'h0000_0001, 1'b0, 2'd1, 32'h2000_0001}, // R4 load bit
    {2'd0, 32'h0000_0007, 1'b0, 2'd0, 32'h0000_0001}, // R2 reject
    {2'd2, 32'hDEAD_BEEF, 1'b0, 2'd2, 32'hDEAD_BEEF}, // R9 compare
    {2'd1, 32'h0004_0004, 1'b0, 2'd1, 32'h2000_0004}, // R5 timing forced
    {2'd1, 32'h0004_0002, 1'b0, 2'd1, 32'h2004_0002}, // R5 timing kept
    {2'd1, 32'hFFFF_FFFF, 1'b1, 2'd1, 32'h280B_FFFF}, // R4 all fields
    {2'd1, 32'h0000_0000, 1'b0, 2'd1, 32'h280B_FFFF}, // R3 ctrl locked
    {2'd2, 32'h0000_1234, 1'b0, 2'd2, 32'hDEAD_BEEF}, // R3 cmp locked
    {2'd1, 32'h0000_0000, 1'b1, 2'd1, 32'h2000_0000}, // R3 unlocked in debug
    {2'd3, 32'hFFFF_FFFF, 1'b0, 2'd3, 32'h0000_0000}  // R6 reserved
  };

  task automatic check(input string req, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [XLEN-1:0] d, input logic dbg);
    @(negedge clk);
    csr_we = 1'b1; csr_addr = a; csr_wdata = d; dbg_mode = dbg;
    @(negedge clk);
    csr_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [XLEN-1:0] d);
    csr_addr = a;
    #1;
    d = csr_rdata;
  endtask

  initial begin
    #(4 * 200000);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [XLEN-1:0] r;
    rst_n = 1'b0; csr_we = 1'b0; csr_addr = 2'd0; csr_wdata = '0; dbg_mode = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(2'd0, r); check("R1 sel", r, 32'h0);
    for (int t = 0; t < NTRIG; t++) begin
      wr(2'd0, 32'(t), 1'b0);
      rd(2'd1, r); check("R1 ctrl type", r, 32'h2000_0000);
      rd(2'd2, r); check("R1 cmp", r, 32'h0);
    end
    check("R1 flags", {29'd0, watch_fetch, watch_load, watch_store}, 32'h0);
    check("R8 select write no pulse", {31'd0, cfg_changed}, 32'h0);
    wr(2'd0, 32'h0, 1'b0);

    for (int v = 0; v < NV; v++) begin
      wr(VEC[v][68:67], VEC[v][66:35], VEC[v][34]);
      rd(VEC[v][33:32], r);
      check($sformatf("vector %0d", v), r, VEC[v][31:0]);
    end

    // R9 other triggers untouched
    wr(2'd0, 32'h0, 1'b0);
    rd(2'd2, r); check("R9 slot0 cmp", r, 32'h0);
    rd(2'd1, r); check("R9 slot0 ctrl", r, 32'h2000_0000);

    // R2 upper bound
    wr(2'd0, 32'd3, 1'b0); rd(2'd0, r); check("R2 sel=3", r, 32'd3);
    wr(2'd0, 32'd4, 1'b0); rd(2'd0, r); check("R2 sel=4 reject", r, 32'd3);

    // R7 and R8 summary flags and pulse
    wr(2'd0, 32'd0, 1'b0);
    wr(2'd1, 32'h0000_0004, 1'b0);
    check("R8 pulse", {31'd0, cfg_changed}, 32'h1);
    check("R7 fetch", {29'd0, watch_fetch, watch_load, watch_store}, 32'h4);
    @(negedge clk);
    check("R8 pulse one cycle", {31'd0, cfg_changed}, 32'h0);
    wr(2'd0, 32'd2, 1'b0);
    wr(2'd1, 32'h0000_0002, 1'b0);
    check("R7 fetch+store", {29'd0, watch_fetch, watch_load, watch_store}, 32'h5);
    wr(2'd1, 32'h0000_0001, 1'b0);
    check("R7 fetch+load", {29'd0, watch_fetch, watch_load, watch_store}, 32'h6);
    wr(2'd0, 32'd0, 1'b0);
    wr(2'd1, 32'h0000_0000, 1'b0);
    check("R7 load only", {29'd0, watch_fetch, watch_load, watch_store}, 32'h2);

    // R8 locked write gives no pulse
    wr(2'd0, 32'd3, 1'b0);
    wr(2'd1, 32'h0800_0000, 1'b1);
    wr(2'd2, 32'h0000_5555, 1'b0);
    check("R8 locked no pulse", {31'd0, cfg_changed}, 32'h0);
    rd(2'd2, r); check("R3 locked cmp", r, 32'h0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule